// File: doc/BRIEF.md
# Flash Driver Operating-Mode Sequencer

This block decides when an LED flash driver's boost converter and current source are switched on. A control byte written over the serial bus selects shutdown, continuous assist (torch) light, or a timed flash. A flash either begins as soon as the write lands, or waits for a rising edge on a strobe pin when the strobe-arm bit is set. Either way it runs for a programmed number of 30 ms steps and then drops back to shutdown by itself.

Two safety paths sit beside the sequencer. A bus-idle watchdog forces shutdown when both bus lines have been low for 35 ms. A fault-stop input blanks both enables in the same cycle it is raised. A 3-bit current code tells the analog current source which level to drive. The control byte can be read back with the block's own updates applied: mode 01 reads as 00, a finished flash reads as shutdown, and the arm bit reads as clear once a strobe has fired.

Control byte layout, used for both write and read-back: bit 7 is strobe arm, bit 6 is zero, bits 5:4 are the mode and bits 3:0 are the step count.

Top module: `flash_seq`

## Requirements
- R1: Mode field 00 and 01 both mean shutdown, with both enables low. A written 01 reads back as 00, 10 selects assist light and 11 selects flash.
- R2: A flash keeps both enables high for exactly (T+1)·STEP_CYC clock cycles, where T is the 4-bit step field and STEP_CYC is 120000 cycles (30 ms at 4 MHz) by default.
- R3: A write of mode 11 with the arm bit clear starts the flash at the clock edge that takes the write, and the enables are high from that edge on.
- R4: When a flash ends by itself, both enables go low and the mode reads back as 00, with the step field unchanged.
- R5: Assist light stays on with no time limit until a write selects another mode.
- R6: When the mode is not shutdown and both bus lines have been low for IDLE_CYC cycles (140000 by default) after a two-flop synchronizer, the mode returns to 00 and the enables drop. Any high level on either line restarts the count.
- R7: A write with the arm bit set makes the mode read back as 11 with no output. A rising edge on the synchronized strobe pin then starts a flash of the programmed length and clears the arm bit. An edge while the block is not armed has no effect.
- R8: A write of 0 to the arm bit and 00 to the mode ends a flash in progress at the edge that takes the write.
- R9: While fault_stop is high, both enables are low in the same cycle, in every mode.
- R10: cur_code is {1, flash level} while a flash runs, {00, assist level} in assist mode, and 000 otherwise.
- R11: After reset both enables are low and the control read-back is 8'h04, which is shutdown with a step count of 4 (150 ms).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle pulse when a control-byte write completes |
| wr_ctl | input | 8 | Written control byte: arm[7], mode[5:4], steps[3:0] |
| flash_lvl | input | 2 | Flash current level, 0..3 |
| assist_lvl | input | 1 | Assist current level, 0..1 |
| strobe_pin | input | 1 | Asynchronous strobe level |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| fault_stop | input | 1 | Fault request that forces the outputs off |
| boost_en | output | 1 | Boost converter enable |
| src_en | output | 1 | Current source enable |
| cur_code | output | 3 | Current selection code |
| ctl_rd | output | 8 | Control byte read-back |

## Verification
The properties assume that wr_stb is a single-cycle pulse that is synchronous to clk, and that the level fields are stable while a flash runs. The stimulus drives every input only on falling edges, holds each write strobe for exactly one cycle, and changes flash_lvl only while the outputs are off. The bus lines and the strobe pin are treated as asynchronous by the design, so the stimulus holds each level for at least three cycles and leaves margin around the synchronizer delay when it checks the watchdog threshold.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int STEP_CYC = 120000,
  parameter int IDLE_CYC = 140000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_ctl,
  input  logic [1:0] flash_lvl,
  input  logic       assist_lvl,
  input  logic       strobe_pin,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       fault_stop,
  output logic       boost_en,
  output logic       src_en,
  output logic [2:0] cur_code,
  output logic [7:0] ctl_rd
);
  localparam int SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam int IW = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYC - 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);

  localparam logic [1:0] M_OFF    = 2'b00;
  localparam logic [1:0] M_ASSIST = 2'b10;
  localparam logic [1:0] M_FLASH  = 2'b11;

  logic [1:0]    mode_r;
  logic [3:0]    tmr_r;
  logic          arm_r;
  logic          run_r;
  logic [SW-1:0] step_cnt;
  logic [3:0]    idx_r;
  logic [1:0]    strb_s, scl_s, sda_s;
  logic          strb_d;
  logic [IW-1:0] idle_cnt;

  wire strobe_rise = strb_s[1] & ~strb_d;
  wire both_low    = ~scl_s[1] & ~sda_s[1];
  wire idle_full   = (idle_cnt == IDLE_LAST);
  wire idle_trip   = both_low & idle_full & (mode_r != M_OFF);
  wire strobe_go   = arm_r & strobe_rise & ~run_r;
  wire step_end    = run_r & (step_cnt == STEP_LAST);
  wire flash_done  = step_end & (idx_r == tmr_r);
  wire lit         = run_r | (mode_r == M_ASSIST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_s   <= 2'b00;
      strb_d   <= 1'b0;
      scl_s    <= 2'b11;
      sda_s    <= 2'b11;
      idle_cnt <= '0;
    end else begin
      strb_s <= {strb_s[0], strobe_pin};
      strb_d <= strb_s[1];
      scl_s  <= {scl_s[0], scl_in};
      sda_s  <= {sda_s[0], sda_in};
      if (!both_low)      idle_cnt <= '0;
      else if (!idle_full) idle_cnt <= idle_cnt + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r   <= M_OFF;
      tmr_r    <= 4'h4;
      arm_r    <= 1'b0;
      run_r    <= 1'b0;
      step_cnt <= '0;
      idx_r    <= 4'h0;
    end else if (wr_stb) begin
      tmr_r    <= wr_ctl[3:0];
      step_cnt <= '0;
      idx_r    <= 4'h0;
      if (wr_ctl[7]) begin
        arm_r  <= 1'b1;
        mode_r <= M_FLASH;
        run_r  <= 1'b0;
      end else begin
        arm_r <= 1'b0;
        case (wr_ctl[5:4])
          M_FLASH:  begin mode_r <= M_FLASH;  run_r <= 1'b1; end
          M_ASSIST: begin mode_r <= M_ASSIST; run_r <= 1'b0; end
          default:  begin mode_r <= M_OFF;    run_r <= 1'b0; end
        endcase
      end
    end else if (idle_trip) begin
      mode_r <= M_OFF;
      arm_r  <= 1'b0;
      run_r  <= 1'b0;
    end else if (strobe_go) begin
      arm_r    <= 1'b0;
      run_r    <= 1'b1;
      step_cnt <= '0;
      idx_r    <= 4'h0;
    end else if (run_r) begin
      if (step_end) begin
        step_cnt <= '0;
        if (flash_done) begin
          run_r  <= 1'b0;
          mode_r <= M_OFF;
        end else begin
          idx_r <= idx_r + 4'd1;
        end
      end else begin
        step_cnt <= step_cnt + SW'(1);
      end
    end
  end

  assign boost_en = lit & ~fault_stop;
  assign src_en   = lit & ~fault_stop;
  assign cur_code = run_r ? {1'b1, flash_lvl} :
                    (mode_r == M_ASSIST) ? {2'b00, assist_lvl} : 3'b000;
  assign ctl_rd   = {arm_r, 1'b0, mode_r, tmr_r};

  p_no_code01_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_r != 2'b01);
  p_run_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_r && !flash_done && !wr_stb && !idle_trip) |=> run_r);
  p_bus_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_ctl[7:4] == 4'b0011) |=> (run_r && src_en == !fault_stop));
  p_self_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_done && !wr_stb && !idle_trip) |=> (mode_r == M_OFF && !run_r));
  p_assist_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == M_ASSIST && !wr_stb && !idle_trip) |=> mode_r == M_ASSIST);
  p_idle_shut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_trip && !wr_stb) |=> (mode_r == M_OFF && !run_r && !arm_r));
  p_strobe_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_go && !wr_stb && !idle_trip) |=> (run_r && !arm_r));
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_ctl[7:4] == 4'b0000) |=> (!src_en && !boost_en));
  p_fault_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_stop |-> (!boost_en && !src_en));
endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
  localparam int CLK_P = 250;
  localparam int STEP  = 20;
  localparam int IDLE  = 50;

  logic clk = 1'b0, rst_n = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_ctl = 8'h00;
  logic [1:0] flash_lvl = 2'b00;
  logic assist_lvl = 1'b0, strobe_pin = 1'b0, scl_in = 1'b1, sda_in = 1'b1, fault_stop = 1'b0;
  logic boost_en, src_en;
  logic [2:0] cur_code;
  logic [7:0] ctl_rd;

  flash_seq #(.STEP_CYC(STEP), .IDLE_CYC(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_ctl(wr_ctl),
    .flash_lvl(flash_lvl), .assist_lvl(assist_lvl), .strobe_pin(strobe_pin),
    .scl_in(scl_in), .sda_in(sda_in), .fault_stop(fault_stop),
    .boost_en(boost_en), .src_en(src_en), .cur_code(cur_code), .ctl_rd(ctl_rd));

  always #(CLK_P/2) clk = ~clk;

  typedef struct { int len; logic [2:0] code; } pulse_t;
  pulse_t exp_q[$];
  int checks = 0, fails = 0;
  bit mon_en = 1'b0, in_p = 1'b0, done = 1'b0;
  int plen = 0;
  logic [2:0] pcode = 3'b000;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_stb = 1'b1; wr_ctl = b;
    @(negedge clk); wr_stb = 1'b0;
    #1;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic push(input int len, input logic [2:0] code);
    pulse_t p;
    p.len = len; p.code = code;
    exp_q.push_back(p);
  endtask

  task automatic wrap_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!mon_en || !rst_n) in_p = 1'b0;
    else if (src_en && cur_code[2]) begin
      if (!in_p) begin in_p = 1'b1; plen = 1; pcode = cur_code; end
      else plen++;
    end else if (in_p) begin
      pulse_t e;
      in_p = 1'b0;
      if (exp_q.size() == 0) chk("R2 unexpected flash pulse", plen, 0);
      else begin
        e = exp_q.pop_front();
        chk("R2 flash length", plen, e.len);
        chk("R10 flash current code", int'(pcode), int'(e.code));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      wrap_up();
    end
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    chk("R11 reset src_en", int'(src_en), 0);
    chk("R11 reset boost_en", int'(boost_en), 0);
    chk("R11 reset readback", int'(ctl_rd), 8'h04);
    mon_en = 1'b1;

    flash_lvl = 2'b10;
    push(5*STEP, 3'b110);
    wr(8'h34);
    chk("R3 flash on after write", int'(src_en), 1);
    chk("R3 readback during flash", int'(ctl_rd), 8'h34);
    cyc(5*STEP + 10);
    chk("R4 off after flash", int'(src_en), 0);
    chk("R4 readback after flash", int'(ctl_rd), 8'h04);

    flash_lvl = 2'b01;
    push(STEP, 3'b101);
    wr(8'h30);
    cyc(STEP + 10);
    flash_lvl = 2'b11;
    push(16*STEP, 3'b111);
    wr(8'h3F);
    cyc(16*STEP + 10);
    chk("R4 readback after long flash", int'(ctl_rd), 8'h0F);

    wr(8'h12);
    chk("R1 mode 01 reads 00", int'(ctl_rd), 8'h02);
    chk("R1 mode 01 output off", int'(src_en), 0);

    assist_lvl = 1'b1;
    wr(8'h20);
    chk("R5 assist on", int'(src_en), 1);
    chk("R5 assist boost on", int'(boost_en), 1);
    chk("R10 assist code high", int'(cur_code), 3'b001);
    cyc(20*STEP);
    chk("R5 assist still on", int'(src_en), 1);
    assist_lvl = 1'b0; #1;
    chk("R10 assist code low", int'(cur_code), 3'b000);
    @(negedge clk); fault_stop = 1'b1; #1;
    chk("R9 fault in assist src", int'(src_en), 0);
    chk("R9 fault in assist boost", int'(boost_en), 0);
    @(negedge clk); fault_stop = 1'b0; #1;
    chk("R9 assist back after fault", int'(src_en), 1);
    wr(8'h00);
    chk("R5 assist off by write", int'(src_en), 0);
    chk("R10 off code", int'(cur_code), 3'b000);

    wr(8'h20);
    @(negedge clk); scl_in = 1'b0; sda_in = 1'b0;
    cyc(IDLE - 3);
    chk("R6 not yet tripped", int'(src_en), 1);
    cyc(10);
    chk("R6 idle trip off", int'(src_en), 0);
    chk("R6 idle trip readback", int'(ctl_rd), 8'h00);
    @(negedge clk); scl_in = 1'b1; sda_in = 1'b1;
    cyc(4);
    wr(8'h20);
    @(negedge clk); scl_in = 1'b0; sda_in = 1'b0;
    cyc(40);
    @(negedge clk); scl_in = 1'b1;
    @(negedge clk); scl_in = 1'b0;
    cyc(40);
    chk("R6 high level restarts count", int'(src_en), 1);
    @(negedge clk); scl_in = 1'b1;
    cyc(2*IDLE);
    chk("R6 one line low only", int'(src_en), 1);
    @(negedge clk); sda_in = 1'b1;
    wr(8'h00);

    mon_en = 1'b0;
    wr(8'h3F);
    @(negedge clk); scl_in = 1'b0; sda_in = 1'b0;
    cyc(IDLE + 5);
    chk("R6 idle trip in flash", int'(src_en), 0);
    chk("R6 idle trip flash readback", int'(ctl_rd), 8'h0F);
    @(negedge clk); scl_in = 1'b1; sda_in = 1'b1;
    cyc(4);
    mon_en = 1'b1;

    flash_lvl = 2'b00;
    wr(8'h82);
    chk("R7 armed readback", int'(ctl_rd), 8'hB2);
    cyc(30);
    chk("R7 armed no output", int'(src_en), 0);
    push(3*STEP, 3'b100);
    @(negedge clk); strobe_pin = 1'b1;
    cyc(5);
    chk("R7 strobe flash on", int'(src_en), 1);
    chk("R7 arm self-cleared", int'(ctl_rd), 8'h32);
    cyc(3*STEP + 5);
    chk("R7 back to shutdown", int'(ctl_rd), 8'h02);
    @(negedge clk); strobe_pin = 1'b0;
    cyc(5);
    @(negedge clk); strobe_pin = 1'b1;
    cyc(10);
    chk("R7 edge unarmed ignored", int'(src_en), 0);
    chk("R7 edge unarmed readback", int'(ctl_rd), 8'h02);
    @(negedge clk); strobe_pin = 1'b0;
    cyc(5);

    mon_en = 1'b0;
    wr(8'h85);
    @(negedge clk); strobe_pin = 1'b1;
    cyc(8);
    chk("R8 strobe flash running", int'(src_en), 1);
    wr(8'h05);
    chk("R8 strobe flash aborted", int'(src_en), 0);
    chk("R8 abort readback", int'(ctl_rd), 8'h05);
    @(negedge clk); strobe_pin = 1'b0;
    wr(8'h3F);
    cyc(10);
    wr(8'h0F);
    chk("R8 bus flash aborted", int'(src_en), 0);

    wr(8'h3F);
    cyc(5);
    @(negedge clk); fault_stop = 1'b1; #1;
    chk("R9 fault in flash src", int'(src_en), 0);
    chk("R9 fault in flash boost", int'(boost_en), 0);
    @(negedge clk); fault_stop = 1'b0;
    wr(8'h00);
    wr(8'h80);
    @(negedge clk); fault_stop = 1'b1; #1;
    chk("R9 fault while armed", int'(src_en), 0);
    @(negedge clk); fault_stop = 1'b0;
    wr(8'h00);
    cyc(5);

    chk("R2 all expected flashes seen", exp_q.size(), 0);
    done = 1'b1;
    wrap_up();
  end
endmodule